// File: doc/BRIEF.md
# Dual Event Counter for a Cache Controller

This block is a small performance monitor placed beside a cache controller. It watches two single-cycle event pulses from the cache: a data read request and a data read hit. It keeps two independent counters, and each counter has its own configuration register that selects which event it counts. Software enables counting, clears either counter and reads the counts back through a simple register bus.

The bus has a valid strobe, a write flag, a 12-bit byte offset and 32-bit data. Read data appears one cycle after the strobe. Any ratio such as a hit rate is computed by software from the two counts. The counters stop at all-ones and do not wrap, so a long run can never report a small value by mistake.

Top module: `perf_evt_pair`

## Requirements
- R1: After synchronous reset, both counters, both config registers, the enable bit and the read data output are all zero.
- R2: A strobe with the write flag set updates the register at the given offset. A strobe with the write flag clear returns that register's value on the read data port in the next cycle, and the port holds that value until the next read strobe. The offsets are: control 0x200, counter A config 0x208, counter B config 0x204, counter B value 0x20C, counter A value 0x210. Any other offset reads as zero, and writes to it or to the two value offsets change nothing.
- R3: A config register reads back the whole 32-bit word last written to it. Its event code is taken from bits [7:2].
- R4: Event code 3 counts read request pulses and event code 2 counts read hit pulses. Each pulse adds one while counting is enabled.
- R5: Code 0 and every other code count nothing. For example, writing the value 0x3 (code 3 left unshifted) gives code 0, so that counter stays where it is.
- R6: Control bit 0 enables counting. A write takes effect from the cycle after the write. Control reads back bit 0 only; all other bits read as zero.
- R7: Writing control bit 1 clears counter A and writing control bit 2 clears counter B. The clear acts only in the cycle of the write and is not stored. Writing 0x7 enables counting and clears both counters.
- R8: When a clear and a counted event fall in the same cycle, the clear wins and the counter ends at zero.
- R9: Counters are CNT_W bits wide (32 by default) and stay at all-ones once they reach it.
- R10: With counter A on read requests and counter B on read hits, both cleared together, the hit count never exceeds the request count.
- R11: Clearing or reconfiguring one counter leaves the other counter's value and counting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| evt_rd_req | input | 1 | Data read request pulse from the cache |
| evt_rd_hit | input | 1 | Data read hit pulse from the cache |

## Verification
The hardest state to reach from the ports is saturation, because a 32-bit counter cannot be filled in a short run. The bench therefore builds the block with an 8-bit counter width and drives a few hundred request pulses, then checks that the value stays at all-ones. A second hard case is a clear that lands in the same cycle as an event pulse. The bench forces it by holding the pulse high during the control write. A behavioural model tracks every cycle, and a pseudo-random pulse stream, in which a hit always comes with a request, tests the hit-versus-request bound.

// File: rtl/perf_evt_pkg.sv
package perf_evt_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int NUM_CNT = 2;
    localparam int CODE_LSB = 2;
    localparam int CODE_W = 6;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h200;
    localparam logic [ADDR_W-1:0] OFF_CFG_A = 12'h208;
    localparam logic [ADDR_W-1:0] OFF_CFG_B = 12'h204;
    localparam logic [ADDR_W-1:0] OFF_VAL_B = 12'h20C;
    localparam logic [ADDR_W-1:0] OFF_VAL_A = 12'h210;

    typedef enum logic [CODE_W-1:0] {
        EVT_OFF    = 6'd0,
        EVT_RD_HIT = 6'd2,
        EVT_RD_REQ = 6'd3
    } evt_code_e;

    typedef struct packed {
        logic rd_req;
        logic rd_hit;
    } evt_pulse_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [CODE_W-1:0] cfg_code(input logic [DATA_W-1:0] cfg);
        return cfg[CODE_LSB +: CODE_W];
    endfunction

    function automatic logic pick_event(input logic [CODE_W-1:0] code, input evt_pulse_t ev);
        case (code)
            EVT_RD_REQ: return ev.rd_req;
            EVT_RD_HIT: return ev.rd_hit;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/perf_evt_regs.sv
module perf_evt_regs
    import perf_evt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  bus_req_t                     req,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_in,
    output logic [NUM_CNT-1:0][DATA_W-1:0] cfg_q,
    output logic                         en_q,
    output logic [NUM_CNT-1:0]           clr,
    output logic [DATA_W-1:0]            rdata
);

    logic wr_hit_ctrl;
    logic rd_stb;

    assign wr_hit_ctrl = req.valid && req.write && (req.addr == OFF_CTRL);
    assign rd_stb      = req.valid && !req.write;

    // one-cycle clear pulses straight from the bus write
    assign clr[0] = wr_hit_ctrl && req.wdata[1];
    assign clr[1] = wr_hit_ctrl && req.wdata[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            en_q  <= 1'b0;
        end else if (req.valid && req.write) begin
            case (req.addr)
                OFF_CTRL:  en_q     <= req.wdata[0];
                OFF_CFG_A: cfg_q[0] <= req.wdata;
                OFF_CFG_B: cfg_q[1] <= req.wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_stb) begin
            case (req.addr)
                OFF_CTRL:  rdata <= {{(DATA_W-1){1'b0}}, en_q};
                OFF_CFG_A: rdata <= cfg_q[0];
                OFF_CFG_B: rdata <= cfg_q[1];
                OFF_VAL_A: rdata <= DATA_W'(cnt_in[0]);
                OFF_VAL_B: rdata <= DATA_W'(cnt_in[1]);
                default:   rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/perf_evt_select.sv
module perf_evt_select
    import perf_evt_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  evt_pulse_t        ev,
    input  logic              en,
    output logic              inc
);

    always_comb begin
        inc = en && pick_event(code, ev);
    end

endmodule

// File: rtl/perf_evt_counter.sv
module perf_evt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/perf_evt_pair.sv
module perf_evt_pair
    import perf_evt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              evt_rd_req,
    input  logic              evt_rd_hit
);

    bus_req_t                       req;
    evt_pulse_t                     ev;
    logic [NUM_CNT-1:0][DATA_W-1:0] cfg_q;
    logic [NUM_CNT-1:0][CODE_W-1:0] evt_code;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_v;
    logic [NUM_CNT-1:0]             clr;
    logic [NUM_CNT-1:0]             inc;
    logic                           en_q;

    assign req = '{valid: bus_valid, write: bus_write, addr: bus_addr, wdata: bus_wdata};
    assign ev  = '{rd_req: evt_rd_req, rd_hit: evt_rd_hit};

    perf_evt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .cnt_in (cnt_v),
        .cfg_q  (cfg_q),
        .en_q   (en_q),
        .clr    (clr),
        .rdata  (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign evt_code[i] = cfg_code(cfg_q[i]);

        perf_evt_select u_sel (
            .code (evt_code[i]),
            .ev   (ev),
            .en   (en_q),
            .inc  (inc[i])
        );

        perf_evt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (clr[i]),
            .inc (inc[i]),
            .cnt (cnt_v[i])
        );
    end

endmodule

// File: rtl/perf_evt_pair_chk.sv
module perf_evt_pair_chk #(
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_valid,
    input logic                  bus_write,
    input logic [31:0]           bus_rdata,
    input logic                  en_q,
    input logic [1:0]            clr,
    input logic [1:0][5:0]       evt_code,
    input logic [1:0][CNT_W-1:0] cnt_v
);

    localparam logic [CNT_W-1:0] ALL1 = '1;

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R8
        clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
            clr[i] |=> (cnt_v[i] == '0));

        // R9
        no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && cnt_v[i] == ALL1) |=> (cnt_v[i] == ALL1));

        // R4
        single_step_chk: assert property (@(posedge clk) disable iff (rst)
            !clr[i] |=> ((cnt_v[i] - $past(cnt_v[i])) <= CNT_W'(1)));

        // R6
        hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && !en_q) |=> $stable(cnt_v[i]));

        // R5
        unknown_code_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr[i] && evt_code[i] != 6'd2 && evt_code[i] != 6'd3) |=> $stable(cnt_v[i]));
    end

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

    // R7
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (clr != 2'b00) |-> (bus_valid && bus_write));

endmodule

bind perf_evt_pair perf_evt_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_rdata (bus_rdata),
    .en_q      (en_q),
    .clr       (clr),
    .evt_code  (evt_code),
    .cnt_v     (cnt_v)
);

// File: tb/perf_evt_pair_tb.sv
module perf_evt_pair_tb;

    localparam int CW = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        evt_rd_req = 1'b0;
    logic        evt_rd_hit = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // behavioural model state
    int          m_cnt [2];
    logic [31:0] m_cfg [2];
    bit          m_en;
    logic [31:0] m_rd;
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    perf_evt_pair #(.CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .evt_rd_req (evt_rd_req),
        .evt_rd_hit (evt_rd_hit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_pick(input logic [31:0] cfg, input bit req, input bit hit);
        case (cfg[7:2])
            6'd3: return req;
            6'd2: return hit;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h200: return {31'd0, m_en};
            12'h208: return m_cfg[0];
            12'h204: return m_cfg[1];
            12'h210: return 32'(m_cnt[0]);
            12'h20C: return 32'(m_cnt[1]);
            default: return 32'd0;
        endcase
    endfunction

    // one bus cycle; drive after negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit v, input bit w, input logic [11:0] a,
                       input logic [31:0] d, input bit req, input bit hit);
        bit c [2];
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        evt_rd_req = req; evt_rd_hit = hit;
        @(posedge clk);
        if (v && !w) m_rd = m_read(a);
        c[0] = v && w && a == 12'h200 && d[1];
        c[1] = v && w && a == 12'h200 && d[2];
        for (int i = 0; i < 2; i++) begin
            if (c[i]) m_cnt[i] = 0;
            else if (m_en && m_pick(m_cfg[i], req, hit) && m_cnt[i] < CMAX) m_cnt[i]++;
        end
        if (v && w) begin
            if (a == 12'h200) m_en = d[0];
            if (a == 12'h208) m_cfg[0] = d;
            if (a == 12'h204) m_cfg[1] = d;
        end
        @(negedge clk);
        check("R2 per-cycle model", bus_rdata, m_rd);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 0, 0);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] val);
        cyc(1, 0, a, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        val = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            bit r, h;
            seed = seed * 1103515245 + 12345;
            r = seed[16];
            h = r && seed[20];
            cyc(0, 0, 0, 0, r, h);
        end
    endtask

    initial begin
        logic [31:0] v, va, vb;
        m_cnt[0] = 0; m_cnt[1] = 0; m_cfg[0] = 0; m_cfg[1] = 0; m_en = 0; m_rd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rdata after reset", bus_rdata, 32'd0);
        rd(12'h210, v); check("R1 counter A after reset", v, 32'd0);
        rd(12'h20C, v); check("R1 counter B after reset", v, 32'd0);
        rd(12'h208, v); check("R1 config A after reset", v, 32'd0);

        wr(12'h208, 32'h0000_000C);
        wr(12'h204, 32'hA500_0008);
        rd(12'h208, v); check("R3 config A readback", v, 32'h0000_000C);
        rd(12'h204, v); check("R3 config B readback", v, 32'hA500_0008);

        wr(12'h200, 32'h7);
        rd(12'h200, v); check("R6 control reads only enable", v, 32'd1);

        pulses(120);
        rd(12'h210, va); rd(12'h20C, vb);
        check("R4 request count", va, 32'(m_cnt[0]));
        check("R4 hit count", vb, 32'(m_cnt[1]));
        checks++;
        if (vb > va || va == 0) begin
            errors++;
            $display("FAIL R10 hit exceeds request: actual hit=%0d req=%0d", vb, va);
        end

        // R8: clear counter A while a request pulse is present
        cyc(1, 1, 12'h200, 32'h3, 1, 1);
        rd(12'h210, v); check("R8 clear beats event", v, 32'd0);
        rd(12'h20C, v); check("R11 counter B unaffected", v, vb + 1);

        // R5: unshifted code and unknown code count nothing
        wr(12'h208, 32'h3);
        wr(12'h204, 32'h14);
        pulses(40);
        rd(12'h210, v); check("R5 unshifted code counts nothing", v, 32'd0);
        rd(12'h20C, v); check("R5 unknown code counts nothing", v, vb + 1);

        // R6: disabled counting
        wr(12'h208, 32'hC);
        wr(12'h200, 32'h0);
        pulses(30);
        rd(12'h210, v); check("R6 no count when disabled", v, 32'd0);

        // R6: enable effective next cycle
        cyc(1, 1, 12'h200, 32'h1, 1, 0);
        cyc(0, 0, 0, 0, 1, 0);
        rd(12'h210, v); check("R6 enable delay", v, 32'd1);

        // R7: clear counter B only, self-clearing
        wr(12'h204, 32'h8);
        cyc(1, 1, 12'h200, 32'h5, 0, 0);
        cyc(0, 0, 0, 0, 1, 1);
        rd(12'h20C, v); check("R7 counter B cleared then counts", v, 32'd1);
        rd(12'h210, v); check("R11 counter A kept", v, 32'd2);

        // R2: unmapped and read-only offsets
        wr(12'h210, 32'hFFFF_FFFF);
        rd(12'h210, v); check("R2 value offset not writable", v, 32'd2);
        rd(12'h100, v); check("R2 unmapped reads zero", v, 32'd0);

        // R9: saturation
        wr(12'h200, 32'h7);
        for (int k = 0; k < CMAX + 40; k++) cyc(0, 0, 0, 0, 1, 0);
        rd(12'h210, v); check("R9 saturates", v, 32'(CMAX));
        cyc(0, 0, 0, 0, 1, 1);
        rd(12'h210, v); check("R9 stays at max", v, 32'(CMAX));
        rd(12'h20C, v); check("R9 counter B", v, 32'(m_cnt[1]));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule